// File: doc/BRIEF.md
# Master Video Sync Timing Generator

This block produces the horizontal and vertical sync strobes for interlaced standard-definition video. It runs on the 27 MHz pixel-rate clock of a multiplexed Cb-Y-Cr-Y sample stream. It keeps a clock-per-sample counter within the line and a line counter within the frame. A single format input chooses between 525-line and 625-line timing. The sync outputs are active low. A field flag gives the parity of the current field, and a vertical-blanking flag marks the lines that carry no picture. That flag can be forced off.

Odd and even fields are told apart by where the vertical strobe falls relative to the horizontal strobe. At the start of an odd field, both strobes fall on the same clock. At the start of an even field, the vertical strobe falls half a line later, while the horizontal strobe is already high again. The block exposes the current line and sample position, so downstream logic can place windows against line numbers.

Top module: `vsync_master_gen`

## Requirements
- R1: `hsync_n` goes low at sample 0 of every line and stays low for exactly HS_WIDTH (default 64) clocks.
- R2: Sample index 0 of the stream is a Cb slot, and every Cb slot has a sample index that is a multiple of four. `hsync_n` therefore only falls when `sample_cnt[1:0] == 0`.
- R3: `sample_cnt` counts 0 to LEN-1 and then returns to 0. LEN is 1716 clocks in 525-line mode and 1728 in 625-line mode. At each wrap, `line_num` steps up by one, and after the last line (525 or 625) it returns to 1.
- R4: `vsync_n` stays low for 3 full lines in 525-line mode and for 2.5 lines in 625-line mode.
- R5: The odd field starts at line 1, sample 0, where `vsync_n` and `hsync_n` fall on the same clock. `field_even` is 0 from there until the even field starts.
- R6: The even field starts at sample LEN/2 of line 263 (525) or line 313 (625), while `hsync_n` is high. `vsync_n` falls there, and `field_even` is 1 from there to the end of the frame.
- R7: In 525-line mode, `vblank` is 1 exactly on lines 1–21, 262–284 and 525.
- R8: In 625-line mode, `vblank` is 1 exactly on lines 1–22, 311–335, 624 and 625.
- R9: While `vbi_off` is 1, `vblank` is 0 on every line, with no delay in either direction.
- R10: `fmt_625` = 0 selects 525-line timing and `fmt_625` = 1 selects 625-line timing.
- R11: Synchronous active-low reset returns the position to line 1, sample 0, odd field. While in reset, both sync outputs are therefore low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock, one multiplexed sample per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| fmt_625 | input | 1 | 0: 525-line timing, 1: 625-line timing |
| vbi_off | input | 1 | 1 forces the blanking flag off |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field_even | output | 1 | 1 during the even field |
| vblank | output | 1 | 1 on vertical-blanking lines |
| line_num | output | 10 | Current line, 1-based |
| sample_cnt | output | 11 | Clock index within the line, 0-based |

## Verification
A wrong internal count shows up first as a misplaced horizontal strobe or a `sample_cnt` that wraps at the wrong value. This becomes visible within one line. A fault in the line counter or in the half-line decode moves the vertical strobe, the field flag or the blanking edges. The bench compares every port on every cycle against an independent model over a whole frame of each format. Any such fault is therefore reported on the first cycle where the port differs. A reduced-length instance keeps whole frames short, and a default-size instance confirms the real line lengths and strobe width.

// File: rtl/vsync_master_gen.sv
module vsync_master_gen #(
  parameter int LINE_CLKS_525  = 1716,
  parameter int LINE_CLKS_625  = 1728,
  parameter int LINES_525      = 525,
  parameter int LINES_625      = 625,
  parameter int HS_WIDTH       = 64,
  parameter int VS_HALVES_525  = 6,
  parameter int VS_HALVES_625  = 5,
  localparam int SW = $clog2((LINE_CLKS_625 > LINE_CLKS_525 ? LINE_CLKS_625 : LINE_CLKS_525) + 1),
  localparam int LW = $clog2((LINES_625 > LINES_525 ? LINES_625 : LINES_525) + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fmt_625,
  input  logic          vbi_off,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          field_even,
  output logic          vblank,
  output logic [LW-1:0] line_num,
  output logic [SW-1:0] sample_cnt
);

  localparam int HW = LW + 1;

  logic [SW-1:0] line_len, half_len;
  logic [LW-1:0] last_line;
  logic [HW-1:0] hidx, frame_halves, vs_halves;
  logic          eol, blank_525, blank_625;

  assign line_len     = fmt_625 ? SW'(LINE_CLKS_625) : SW'(LINE_CLKS_525);
  assign half_len     = line_len >> 1;
  assign last_line    = fmt_625 ? LW'(LINES_625) : LW'(LINES_525);
  assign frame_halves = fmt_625 ? HW'(LINES_625) : HW'(LINES_525);
  assign vs_halves    = fmt_625 ? HW'(VS_HALVES_625) : HW'(VS_HALVES_525);
  assign eol          = sample_cnt >= line_len - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_cnt <= '0;
      line_num   <= LW'(1);
    end else if (eol) begin
      sample_cnt <= '0;
      line_num   <= (line_num >= last_line) ? LW'(1) : line_num + 1'b1;
    end else begin
      sample_cnt <= sample_cnt + 1'b1;
    end
  end

  assign hidx = {line_num - 1'b1, sample_cnt >= half_len};

  assign hsync_n    = !(sample_cnt < SW'(HS_WIDTH));
  assign field_even = hidx >= frame_halves;
  assign vsync_n    = !((hidx < vs_halves) ||
                        (field_even && hidx < frame_halves + vs_halves));

  assign blank_525 = (line_num <= LW'(21)) ||
                     (line_num >= LW'(262) && line_num <= LW'(284)) ||
                     (line_num == LW'(LINES_525));
  assign blank_625 = (line_num <= LW'(22)) ||
                     (line_num >= LW'(311) && line_num <= LW'(335)) ||
                     (line_num >= LW'(LINES_625 - 1));
  assign vblank    = !vbi_off && (fmt_625 ? blank_625 : blank_525);

endmodule

// File: rtl/vsync_master_chk.sv
module vsync_master_chk #(
  parameter int LINE_CLKS_525 = 1716,
  parameter int LINE_CLKS_625 = 1728,
  parameter int LINES_525     = 525,
  parameter int LINES_625     = 625,
  parameter int HS_WIDTH      = 64,
  parameter int SW            = 11,
  parameter int LW            = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fmt_625,
  input logic          vbi_off,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          field_even,
  input logic          vblank,
  input logic [LW-1:0] line_num,
  input logic [SW-1:0] sample_cnt
);

  logic [15:0] hs_lo, vs_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_lo <= '0;
      vs_lo <= '0;
    end else begin
      hs_lo <= hsync_n ? '0 : hs_lo + 1'b1;
      vs_lo <= vsync_n ? '0 : vs_lo + 1'b1;
    end
  end

  p_hs_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync_n) |-> hs_lo == 16'(HS_WIDTH));

  p_hs_cb_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |-> sample_cnt[1:0] == 2'b00);

  p_line_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_num >= LW'(1) && line_num <= LW'(fmt_625 ? LINES_625 : LINES_525));

  p_vs_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync_n) |-> vs_lo == (fmt_625 ? 16'(5 * LINE_CLKS_625 / 2)
                                         : 16'(3 * LINE_CLKS_525)));

  p_odd_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vsync_n) && $fell(hsync_n)) |-> (line_num == LW'(1) && !field_even));

  p_even_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vsync_n) && hsync_n) |-> field_even);

  p_blank_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vbi_off |-> !vblank);

endmodule

bind vsync_master_gen vsync_master_chk #(
  .LINE_CLKS_525(LINE_CLKS_525), .LINE_CLKS_625(LINE_CLKS_625),
  .LINES_525(LINES_525), .LINES_625(LINES_625), .HS_WIDTH(HS_WIDTH),
  .SW(SW), .LW(LW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt_625(fmt_625), .vbi_off(vbi_off),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .field_even(field_even),
  .vblank(vblank), .line_num(line_num), .sample_cnt(sample_cnt)
);

// File: tb/vsync_master_gen_tb_top.sv
module vsync_master_gen_tb_top;

  localparam int S525 = 120;
  localparam int S625 = 128;
  localparam int SHS  = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done_s = 0, done_i = 0;

  logic rst_s = 0, fmt_s = 0, vbi_s = 0;
  logic hs_s, vs_s, fe_s, vb_s;
  logic [9:0] ln_s;
  logic [7:0] sc_s;

  logic rst_i = 0, fmt_i = 0, vbi_i = 0;
  logic hs_i, vs_i, fe_i, vb_i;
  logic [9:0]  ln_i;
  logic [10:0] sc_i;

  vsync_master_gen #(.LINE_CLKS_525(S525), .LINE_CLKS_625(S625), .HS_WIDTH(SHS)) dut_s (
    .clk(clk), .rst_n(rst_s), .fmt_625(fmt_s), .vbi_off(vbi_s),
    .hsync_n(hs_s), .vsync_n(vs_s), .field_even(fe_s), .vblank(vb_s),
    .line_num(ln_s), .sample_cnt(sc_s));

  vsync_master_gen dut_i (
    .clk(clk), .rst_n(rst_i), .fmt_625(fmt_i), .vbi_off(vbi_i),
    .hsync_n(hs_i), .vsync_n(vs_i), .field_even(fe_i), .vblank(vb_i),
    .line_num(ln_i), .sample_cnt(sc_i));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_vs_low(bit f, int ln, int s, int len);
    int h = len / 2;
    if (!f) return (ln <= 3) || (ln == 263 && s >= h) || ln == 264 || ln == 265 ||
                   (ln == 266 && s < h);
    return (ln <= 2) || (ln == 3 && s < h) || (ln == 313 && s >= h) ||
           ln == 314 || ln == 315;
  endfunction

  function automatic bit m_even(bit f, int ln, int s, int len);
    int e = f ? 313 : 263;
    return (ln > e) || (ln == e && s >= len / 2);
  endfunction

  function automatic bit m_blank(bit f, bit off, int ln);
    if (off) return 0;
    if (!f) return (ln <= 21) || (ln >= 262 && ln <= 284) || ln == 525;
    return (ln <= 22) || (ln >= 311 && ln <= 335) || ln >= 624;
  endfunction

  task automatic run_frame(input bit f);
    int len   = f ? S625 : S525;
    int lines = f ? 625 : 525;
    int total = len * lines + 2 * len;
    int ln = 1, s = 0;
    rst_s = 0;
    fmt_s = f;
    repeat (3) @(negedge clk);
    rst_s = 1;
    chk(ln_s == 10'd1 && sc_s == 8'd0, "R11 reset position", int'(sc_s), 0);
    chk(!fe_s && !vs_s && !hs_s, "R11 reset field/sync", int'({fe_s, vs_s, hs_s}), 0);
    for (int k = 0; k < total; k++) begin
      chk(int'(ln_s) == ln, f ? "R3 R10 line_num 625" : "R3 R10 line_num 525", int'(ln_s), ln);
      chk(int'(sc_s) == s, "R3 sample_cnt", int'(sc_s), s);
      chk(hs_s == !(s < SHS), "R1 hsync_n", int'(hs_s), int'(!(s < SHS)));
      chk(vs_s == !m_vs_low(f, ln, s, len), "R4 R5 R6 vsync_n", int'(vs_s),
          int'(!m_vs_low(f, ln, s, len)));
      chk(fe_s == m_even(f, ln, s, len), m_even(f, ln, s, len) ? "R6 field_even" : "R5 field_even",
          int'(fe_s), int'(m_even(f, ln, s, len)));
      chk(vb_s == m_blank(f, vbi_s, ln), vbi_s ? "R9 vblank" : (f ? "R8 vblank" : "R7 vblank"),
          int'(vb_s), int'(m_blank(f, vbi_s, ln)));
      if ($urandom % 40 == 0) vbi_s = ~vbi_s;
      @(negedge clk);
      if (s == len - 1) begin
        s = 0;
        ln = (ln == lines) ? 1 : ln + 1;
      end else s++;
    end
  endtask

  task automatic run_full(input bit f);
    int len = f ? 1728 : 1716;
    int vend = f ? (5 * len / 2) : 3 * len;
    int lo = 0;
    logic prev;
    rst_i = 0;
    fmt_i = f;
    repeat (3) @(negedge clk);
    rst_i = 1;
    prev = hs_i;
    for (int c = 0; c <= 3 * len + 80; c++) begin
      if (!hs_i) lo++;
      if (hs_i && !prev) chk(lo == 64, "R1 hsync width", lo, 64);
      if (hs_i) lo = 0;
      if (!hs_i && prev) begin
        chk(c % len == 0, f ? "R3 R10 line period 625" : "R3 R10 line period 525", c, (c / len) * len);
        chk(sc_i[1:0] == 2'b00, "R2 Cb slot", int'(sc_i[1:0]), 0);
        chk(int'(ln_i) == c / len + 1, "R3 line step", int'(ln_i), c / len + 1);
      end
      if (c == vend - 1) chk(!vs_i, "R4 vsync still low", int'(vs_i), 0);
      if (c == vend) chk(vs_i, "R4 vsync released", int'(vs_i), 1);
      prev = hs_i;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_full(1'b0);
    run_full(1'b1);
    done_i = 1;
  end

  initial begin
    @(negedge clk);
    run_frame(1'b0);
    run_frame(1'b1);
    done_s = 1;
  end

  initial begin
    fork
      begin
        wait (done_s && done_i);
      end
      begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 195000, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule